// File: doc/BRIEF.md
# Floating-Point Sign Injection, Compare and Min/Max Unit

This block performs the non-arithmetic single-precision operations of a floating-point datapath in one registered stage. It injects signs, compares two operands, and selects the smaller or larger of two operands. Two 32-bit operands, a 2-bit operation select and a 3-bit sub-operation code `rm` go in. One clock edge later come out a 32-bit result and a 5-bit exception flag vector. The result is a float for sign injection and min/max, and 0 or 1 for comparisons.

The `rm` field picks the sub-operation within each operation. Every NaN the block creates itself is the one canonical quiet pattern. Signaling NaNs are detected and reported through the invalid flag. Quiet comparisons report them differently from signaling comparisons. Sign injection is a pure bit operation and carries any NaN payload through untouched.

Top module: `fp_cmpsel_unit`

## Requirements
- R1: The result and flags are registered: the values driven before a rising clock edge appear on `res` and `fflags` after that edge and stay until the next edge. While `rst_n` is low, both outputs are zero.
- R2: With `op_sel`=00 (sign injection), bits 30:0 of the result come from `op_a`. The sign comes from one of three sources: `rm`=000 copies the sign of `op_b`, `rm`=001 copies the inverted sign of `op_b`, and `rm`=010 uses the XOR of both signs. No flag is raised, and NaN payloads (signaling or quiet) pass through unchanged.
- R3: With `op_sel`=01 (compare), `rm`=000 tests a==b, `rm`=001 tests a<b and `rm`=010 tests a<=b. The outcome is placed in bit 0 of the result and bits 31:1 are zero. +0 and -0 compare equal.
- R4: A NaN is an operand whose exponent bits 30:23 are all ones and whose fraction bits 22:0 are nonzero. It is quiet if bit 22 is set and signaling otherwise. A compare with any NaN operand returns 0. The equality test raises invalid only for a signaling NaN operand, while the less-than and less-or-equal tests raise invalid for any NaN operand.
- R5: With `op_sel`=10 (min/max), `rm`=000 returns the smaller operand and `rm`=001 returns the larger one. In this ordering -0 is smaller than +0.
- R6: For min/max, if exactly one operand is a NaN the other operand is returned. If both are NaN the result is 0x7FC00000. Invalid is raised if either operand is a signaling NaN.
- R7: The flag vector layout is inexact=bit0, underflow=bit1, overflow=bit2, divide-by-zero=bit3, invalid=bit4. This block only ever sets bit 4.
- R8: `op_sel`=11 and any `rm` code not listed for the selected operation produce a result of zero and no flags, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 2 | Operation: 00 sign injection, 01 compare, 10 min/max, 11 reserved |
| rm | input | 3 | Sub-operation code within the selected operation |
| res | output | 32 | Registered result |
| fflags | output | 5 | Registered exception flags, invalid in bit 4 |

## Verification
The bench focuses on the cases that a plain integer comparison gets wrong:
- **Signed zeros.** Equality of +0 and -0 is tested, where a raw bit compare would return 0. Min/max on the two zeros is also tested, where a magnitude-only ordering could return either zero.
- **Negative operands.** Two negative operands are compared, where an unsigned compare reverses the answer.
- **NaN flags.** Quiet and signaling NaNs go into each compare mode. A design that treats equality as a signaling compare would raise invalid on a quiet NaN, and one that forgets the ordered tests would stay silent.
- **NaN results.** Min/max is driven with one NaN and with two. Returning the NaN operand itself, or a payload other than 0x7FC00000, shows up as a wrong result.
- **Reserved codes and payloads.** Reserved codes are fed signaling NaNs to expose stray flags. Sign injection of a signaling NaN catches a design that quiets or canonicalises it.

// File: rtl/fpcs_pkg.sv
package fpcs_pkg;

   typedef enum logic [1:0] {
      OPS_SGNJ   = 2'b00,
      OPS_CMP    = 2'b01,
      OPS_MINMAX = 2'b10,
      OPS_RSVD   = 2'b11
   } fpcs_op_e;

   typedef struct packed {
      logic is_nan;
      logic is_snan;
      logic is_zero;
      logic sign;
   } fpcs_class_t;

   localparam int FLAG_W  = 5;
   localparam int FLAG_NV = 4;

endpackage

// File: rtl/fpcs_classify.sv
module fpcs_classify
   import fpcs_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] val,
   output fpcs_class_t          cls
);
   localparam int W = EXP_W + MAN_W + 1;

   logic exp_ones;
   logic frac_nz;

   always_comb begin
      exp_ones    = &val[W-2:MAN_W];
      frac_nz     = |val[MAN_W-1:0];
      cls.sign    = val[W-1];
      cls.is_zero = ~|val[W-2:0];
      cls.is_nan  = exp_ones & frac_nz;
      cls.is_snan = exp_ones & frac_nz & ~val[MAN_W-1];
   end
endmodule

// File: rtl/fpcs_order.sv
module fpcs_order
   import fpcs_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] a,
   input  logic [EXP_W+MAN_W:0] b,
   input  fpcs_class_t          ca,
   input  fpcs_class_t          cb,
   output logic                 eq,
   output logic                 lt,
   output logic                 lt_total
);
   localparam int W = EXP_W + MAN_W + 1;

   logic both_zero;
   logic mag_lt;
   logic mag_gt;

   always_comb begin
      both_zero = ca.is_zero & cb.is_zero;
      mag_lt    = a[W-2:0] < b[W-2:0];
      mag_gt    = a[W-2:0] > b[W-2:0];
      eq        = (a == b) | both_zero;
      if (both_zero)
         lt = 1'b0;
      else if (ca.sign != cb.sign)
         lt = ca.sign;
      else if (ca.sign)
         lt = mag_gt;
      else
         lt = mag_lt;
      lt_total = lt | (both_zero & ca.sign & ~cb.sign);
   end
endmodule

// File: rtl/fpcs_sgnj.sv
module fpcs_sgnj #(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] a,
   input  logic [EXP_W+MAN_W:0] b,
   input  logic [2:0]           rm,
   output logic [EXP_W+MAN_W:0] res,
   output logic                 legal
);
   localparam int W = EXP_W + MAN_W + 1;

   logic new_sign;

   always_comb begin
      legal    = 1'b1;
      new_sign = 1'b0;
      unique case (rm)
         3'b000:  new_sign = b[W-1];
         3'b001:  new_sign = ~b[W-1];
         3'b010:  new_sign = a[W-1] ^ b[W-1];
         default: legal = 1'b0;
      endcase
      res = {new_sign, a[W-2:0]};
   end
endmodule

// File: rtl/fpcs_compare.sv
module fpcs_compare
   import fpcs_pkg::*;
(
   input  fpcs_class_t ca,
   input  fpcs_class_t cb,
   input  logic        eq,
   input  logic        lt,
   input  logic [2:0]  rm,
   output logic        bit_out,
   output logic        nv,
   output logic        legal
);
   logic any_nan;
   logic any_snan;

   always_comb begin
      any_nan  = ca.is_nan | cb.is_nan;
      any_snan = ca.is_snan | cb.is_snan;
      legal    = 1'b1;
      bit_out  = 1'b0;
      nv       = 1'b0;
      unique case (rm)
         3'b000: begin
            bit_out = eq & ~any_nan;
            nv      = any_snan;
         end
         3'b001: begin
            bit_out = lt & ~any_nan;
            nv      = any_nan;
         end
         3'b010: begin
            bit_out = (lt | eq) & ~any_nan;
            nv      = any_nan;
         end
         default: legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/fpcs_minmax.sv
module fpcs_minmax
   import fpcs_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] a,
   input  logic [EXP_W+MAN_W:0] b,
   input  fpcs_class_t          ca,
   input  fpcs_class_t          cb,
   input  logic                 lt_total,
   input  logic [2:0]           rm,
   output logic [EXP_W+MAN_W:0] res,
   output logic                 nv,
   output logic                 legal
);
   localparam int W = EXP_W + MAN_W + 1;
   localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic want_max;

   always_comb begin
      legal    = (rm == 3'b000) || (rm == 3'b001);
      want_max = rm[0];
      nv       = ca.is_snan | cb.is_snan;
      if (ca.is_nan && cb.is_nan)
         res = CANON_NAN;
      else if (ca.is_nan)
         res = b;
      else if (cb.is_nan)
         res = a;
      else if (want_max)
         res = lt_total ? b : a;
      else
         res = lt_total ? a : b;
   end
endmodule

// File: rtl/fp_cmpsel_unit.sv
module fp_cmpsel_unit
   import fpcs_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [EXP_W+MAN_W:0] op_a,
   input  logic [EXP_W+MAN_W:0] op_b,
   input  logic [1:0]           op_sel,
   input  logic [2:0]           rm,
   output logic [EXP_W+MAN_W:0] res,
   output logic [FLAG_W-1:0]    fflags
);
   localparam int W = EXP_W + MAN_W + 1;

   if (EXP_W < 2) begin : g_bad_exp
      $error("fp_cmpsel_unit: EXP_W must be at least 2");
   end
   if (MAN_W < 2) begin : g_bad_man
      $error("fp_cmpsel_unit: MAN_W must be at least 2");
   end

   logic [W-1:0] opnd [2];
   fpcs_class_t  cls  [2];

   assign opnd[0] = op_a;
   assign opnd[1] = op_b;

   for (genvar gi = 0; gi < 2; gi++) begin : g_cls
      fpcs_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
         .val (opnd[gi]),
         .cls (cls[gi])
      );
   end

   logic eq, lt, lt_total;

   fpcs_order #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_order (
      .a        (op_a),
      .b        (op_b),
      .ca       (cls[0]),
      .cb       (cls[1]),
      .eq       (eq),
      .lt       (lt),
      .lt_total (lt_total)
   );

   logic [W-1:0] sgnj_res;
   logic         sgnj_legal;

   fpcs_sgnj #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sgnj (
      .a     (op_a),
      .b     (op_b),
      .rm    (rm),
      .res   (sgnj_res),
      .legal (sgnj_legal)
   );

   logic cmp_bit, cmp_nv, cmp_legal;

   fpcs_compare u_cmp (
      .ca      (cls[0]),
      .cb      (cls[1]),
      .eq      (eq),
      .lt      (lt),
      .rm      (rm),
      .bit_out (cmp_bit),
      .nv      (cmp_nv),
      .legal   (cmp_legal)
   );

   logic [W-1:0] mm_res;
   logic         mm_nv, mm_legal;

   fpcs_minmax #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mm (
      .a        (op_a),
      .b        (op_b),
      .ca       (cls[0]),
      .cb       (cls[1]),
      .lt_total (lt_total),
      .rm       (rm),
      .res      (mm_res),
      .nv       (mm_nv),
      .legal    (mm_legal)
   );

   logic [W-1:0]      nxt_res;
   logic [FLAG_W-1:0] nxt_flags;

   always_comb begin
      nxt_res   = '0;
      nxt_flags = '0;
      unique case (fpcs_op_e'(op_sel))
         OPS_SGNJ: begin
            if (sgnj_legal) nxt_res = sgnj_res;
         end
         OPS_CMP: begin
            if (cmp_legal) begin
               nxt_res[0]         = cmp_bit;
               nxt_flags[FLAG_NV] = cmp_nv;
            end
         end
         OPS_MINMAX: begin
            if (mm_legal) begin
               nxt_res            = mm_res;
               nxt_flags[FLAG_NV] = mm_nv;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res    <= '0;
         fflags <= '0;
      end else begin
         res    <= nxt_res;
         fflags <= nxt_flags;
      end
   end
endmodule

// File: rtl/fpcs_checker.sv
module fpcs_checker
   import fpcs_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [EXP_W+MAN_W:0] op_a,
   input logic [EXP_W+MAN_W:0] op_b,
   input logic [1:0]           op_sel,
   input logic [2:0]           rm,
   input logic [EXP_W+MAN_W:0] res,
   input logic [FLAG_W-1:0]    fflags
);
   localparam int W = EXP_W + MAN_W + 1;
   localparam logic [W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

   logic a_nan, b_nan, r_nan;
   assign a_nan = (op_a[W-2:MAN_W] == {EXP_W{1'b1}}) && (op_a[MAN_W-1:0] != '0);
   assign b_nan = (op_b[W-2:MAN_W] == {EXP_W{1'b1}}) && (op_b[MAN_W-1:0] != '0);
   assign r_nan = (res[W-2:MAN_W] == {EXP_W{1'b1}}) && (res[MAN_W-1:0] != '0);

   assert_sgnj_mag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b00 && rm <= 3'b010) |=> (res[W-2:0] == $past(op_a[W-2:0]) && fflags == '0));

   assert_cmp_bool_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b01) |=> (res[W-1:1] == '0));

   assert_cmp_nan_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b01 && (a_nan || b_nan)) |=> (res == '0));

   assert_minmax_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b10 && rm <= 3'b001) |=>
         (res == $past(op_a) || res == $past(op_b) || res == CANON));

   assert_canon_nan_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel != 2'b00) |=> (!r_nan || res == CANON));

   assert_flag_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel != 2'b00 || op_sel == 2'b00) |=> (fflags[FLAG_W-2:0] == '0));

   assert_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 2'b11) |=> (res == '0 && fflags == '0));
endmodule

bind fp_cmpsel_unit fpcs_checker #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .op_a   (op_a),
   .op_b   (op_b),
   .op_sel (op_sel),
   .rm     (rm),
   .res    (res),
   .fflags (fflags)
);

// File: tb/sim_fp_cmpsel_unit.sv
module sim_fp_cmpsel_unit;
   localparam int PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic [1:0]  op_sel = 2'b11;
   logic [2:0]  rm = '0;
   logic [31:0] res;
   logic [4:0]  fflags;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      logic [31:0] r;
      logic [4:0]  f;
      string       tag;
   } exp_t;

   exp_t sb[$];

   always #(PERIOD/2) clk = ~clk;

   fp_cmpsel_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .op_sel(op_sel), .rm(rm), .res(res), .fflags(fflags)
   );

   task automatic drive(input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] o, input logic [2:0] m,
                        input logic [31:0] er, input logic [4:0] ef,
                        input string tag);
      exp_t e;
      @(negedge clk);
      op_a = a; op_b = b; op_sel = o; rm = m;
      e.r = er; e.f = ef; e.tag = tag;
      sb.push_back(e);
   endtask

   initial begin : monitor
      forever begin
         @(posedge clk);
         #(PERIOD/4);
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_run++;
            if (res !== e.r || fflags !== e.f) begin
               n_fail++;
               $display("FAIL %s: res=%h flags=%b expected res=%h flags=%b",
                        e.tag, res, fflags, e.r, e.f);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   localparam logic [31:0] P1 = 32'h3F800000, P2 = 32'h40000000;
   localparam logic [31:0] N1 = 32'hBF800000, N2 = 32'hC0000000;
   localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
   localparam logic [31:0] QN = 32'h7FC00000, QNP = 32'h7FC12345;
   localparam logic [31:0] SN = 32'h7F800001;
   localparam logic [4:0]  NV = 5'b10000;

   initial begin : driver
      // R1: reset state, with non-zero inputs applied while in reset
      op_a = P1; op_b = P2; op_sel = 2'b00; rm = 3'b000;
      repeat (3) @(posedge clk);
      #(PERIOD/4);
      n_run++;
      if (res !== 32'h0 || fflags !== 5'h0) begin
         n_fail++;
         $display("FAIL R1 reset: res=%h flags=%b expected res=%h flags=%b", res, fflags, 32'h0, 5'h0);
      end
      @(negedge clk);
      rst_n = 1'b1;

      // R2 sign injection
      drive(P1, N2, 2'b00, 3'b000, N1, 5'h0, "R2 copy sign");
      drive(P1, N2, 2'b00, 3'b001, P1, 5'h0, "R2 inverted sign");
      drive(N1, N2, 2'b00, 3'b010, P1, 5'h0, "R2 xor sign");
      drive(SN, NZ, 2'b00, 3'b000, 32'hFF800001, 5'h0, "R2 snan payload kept");
      drive(QNP, PZ, 2'b00, 3'b001, 32'hFFC12345, 5'h0, "R2 qnan payload kept");
      // R3 compare
      drive(P1, P1, 2'b01, 3'b000, 32'h1, 5'h0, "R3 eq equal");
      drive(PZ, NZ, 2'b01, 3'b000, 32'h1, 5'h0, "R3 eq signed zeros");
      drive(N1, P1, 2'b01, 3'b001, 32'h1, 5'h0, "R3 lt mixed sign");
      drive(NZ, PZ, 2'b01, 3'b001, 32'h0, 5'h0, "R3 lt zeros");
      drive(NZ, PZ, 2'b01, 3'b010, 32'h1, 5'h0, "R3 le zeros");
      drive(N2, N1, 2'b01, 3'b001, 32'h1, 5'h0, "R3 lt negatives");
      drive(P2, P1, 2'b01, 3'b010, 32'h0, 5'h0, "R3 le false");
      // R4 / R7 compare with NaN
      drive(QN, P1, 2'b01, 3'b000, 32'h0, 5'h0, "R4 eq qnan quiet");
      drive(SN, P1, 2'b01, 3'b000, 32'h0, NV, "R4 R7 eq snan invalid");
      drive(QN, P1, 2'b01, 3'b001, 32'h0, NV, "R4 R7 lt qnan invalid");
      drive(P1, QN, 2'b01, 3'b010, 32'h0, NV, "R4 le qnan invalid");
      // R5 min/max
      drive(P1, P2, 2'b10, 3'b000, P1, 5'h0, "R5 min");
      drive(N1, N2, 2'b10, 3'b001, N1, 5'h0, "R5 max negatives");
      drive(PZ, NZ, 2'b10, 3'b000, NZ, 5'h0, "R5 min zeros");
      drive(NZ, PZ, 2'b10, 3'b001, PZ, 5'h0, "R5 max zeros");
      // R6 min/max with NaN
      drive(QN, P2, 2'b10, 3'b000, P2, 5'h0, "R6 one qnan");
      drive(SN, N1, 2'b10, 3'b001, N1, NV, "R6 R7 one snan");
      drive(QNP, QNP, 2'b10, 3'b000, QN, 5'h0, "R6 two qnan canonical");
      drive(QNP, SN, 2'b10, 3'b001, QN, NV, "R6 snan and qnan");
      // R8 reserved codes
      drive(SN, SN, 2'b11, 3'b000, 32'h0, 5'h0, "R8 reserved op");
      drive(P1, N2, 2'b00, 3'b011, 32'h0, 5'h0, "R8 sgnj bad rm");
      drive(SN, P1, 2'b01, 3'b011, 32'h0, 5'h0, "R8 cmp bad rm");
      drive(SN, P1, 2'b10, 3'b010, 32'h0, 5'h0, "R8 minmax bad rm");
      // R1: held inputs give the same registered output
      drive(P1, P2, 2'b10, 3'b001, P2, 5'h0, "R1 hold first");
      drive(P1, P2, 2'b10, 3'b001, P2, 5'h0, "R1 hold second");

      @(negedge clk);
      op_sel = 2'b11;
      while (sb.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule